// File: doc/BRIEF.md
# Interleaved YUV Stream Sequencer

This block lets a single 5-tap filter serve three pixel components at once. Luma and the two chroma streams arrive one sample at a time on a shared input. A small sequence counter decides which component is being fed in this cycle. That component's private delay chain takes the sample, and the block presents the chain's five taps to the filter. Alongside the taps it presents the five coefficient-select codes that belong to that component. The filter itself is outside the block and hands its result back one cycle later.

Chroma results are parked in two holding registers. Each luma result is emitted together with the most recently parked U and V as one 4:4:4 output pixel. A half-rate setting inserts a second luma step after every chroma pair, which gives 4:2:2 style reuse of each U/V pair. A line-start pulse returns the sequence to the U phase without disturbing any stored sample history.

Top module: `yuv_interleave_seq`

## Requirements
- R1: After reset `phase_o` is 0 (U), `tap_vld_o` and `pix_vld_o` are low, and every delay stage and holding register is zero.
- R2: With `half_rate_i` low, each cycle with `en_i` high and `line_start_i` low moves `phase_o` through 0 (U), 1 (V), 2 (Y) and then back to 0. Code 3 never appears in this mode.
- R3: With `half_rate_i` high, the phase order is 0, 1, 2, 3, 0. Codes 2 and 3 both select the Y stream, so each U/V pair serves two Y samples.
- R4: On an advancing cycle, only the selected stream's four-stage delay chain shifts `pix_i` in. One cycle later `taps_o` holds that stream's five taps: tap k sits in bits [k*PIX_W +: PIX_W], with tap 0 being the new sample and taps 1 to 4 being the earlier samples of the same stream, newest first. The other two chains keep their contents.
- R5: In the same cycle as the taps, `csel_o` carries the selected component's coefficient-select set (`coef_u_i`, `coef_v_i` or `coef_y_i`), `tap_comp_o` carries the phase code that was used, and `tap_vld_o` is high. `tap_vld_o` is low after any cycle that did not advance.
- R6: `filt_i` is sampled one cycle after `tap_vld_o`. A U result is stored as held U, and a V result is stored as held V.
- R7: A Y result (phase code 2 or 3) appears one cycle later on `pix_y_o`, with `pix_vld_o` high. In the same cycle `pix_u_o` and `pix_v_o` show the held U and V. `pix_vld_o` is never high for a chroma result.
- R8: When `line_start_i` is high, `phase_o` returns to 0 in the next cycle and no stream advances, whatever the value of `en_i`. The stored samples in the delay chains are kept.
- R9: With `en_i` low and `line_start_i` low, the phase and all delay chains keep their values and `tap_vld_o` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Advance the sequence and accept `pix_i` |
| line_start_i | input | 1 | Restart the sequence at the U phase |
| half_rate_i | input | 1 | Select U,V,Y,Y order for 4:2:2 chroma reuse |
| pix_i | input | PIX_W | Sample for the component named by `phase_o` |
| coef_u_i | input | TAPS*CSEL_W | Coefficient-select codes for U |
| coef_v_i | input | TAPS*CSEL_W | Coefficient-select codes for V |
| coef_y_i | input | TAPS*CSEL_W | Coefficient-select codes for Y |
| filt_i | input | PIX_W | Filter result for the taps presented in the previous cycle |
| phase_o | output | 2 | Current sequence code (0 U, 1 V, 2/3 Y) |
| tap_vld_o | output | 1 | Taps and codes below are fresh |
| tap_comp_o | output | 2 | Phase code of the presented taps |
| taps_o | output | TAPS*PIX_W | Five taps of the selected stream |
| csel_o | output | TAPS*CSEL_W | Coefficient-select codes of the selected stream |
| pix_vld_o | output | 1 | Output pixel valid |
| pix_y_o | output | PIX_W | Filtered luma |
| pix_u_o | output | PIX_W | Held filtered U |
| pix_v_o | output | PIX_W | Held filtered V |

## Verification
The bench sweeps both rate modes against every stall spacing and restarts lines at every phase. This catches a counter that reaches code 3 in full-rate mode, or one that skips the second Y step in half-rate mode. It checks the taps after each step. A chain that shifts on another stream's turn, or that shifts during a stall or a line-start cycle, then shows wrong or stale history. It also compares each output pixel against a filter model kept in the bench. That comparison exposes holding registers that capture the wrong component and a valid flag raised on chroma results.

// File: rtl/yuv_seq_pkg.sv
package yuv_seq_pkg;
  typedef enum logic [1:0] {
    PH_U  = 2'd0,
    PH_V  = 2'd1,
    PH_Y0 = 2'd2,
    PH_Y1 = 2'd3
  } phase_e;

  localparam int NUM_STREAMS = 3;

  function automatic int stream_of(input logic [1:0] ph);
    return ph[1] ? 2 : int'(ph[0]);
  endfunction
endpackage

// File: rtl/yuv_seq_ctr.sv
module yuv_seq_ctr
  import yuv_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en_i,
  input  logic       line_start_i,
  input  logic       half_rate_i,
  output logic [1:0] phase_o,
  output logic       adv_o
);
  logic [1:0] ph_q;
  logic [1:0] ph_nxt;

  assign adv_o   = en_i && !line_start_i;
  assign phase_o = ph_q;

  always_comb begin
    case (ph_q)
      PH_U:    ph_nxt = PH_V;
      PH_V:    ph_nxt = PH_Y0;
      PH_Y0:   ph_nxt = half_rate_i ? PH_Y1 : PH_U;
      default: ph_nxt = PH_U;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || line_start_i) ph_q <= PH_U;
    else if (adv_o)          ph_q <= ph_nxt;
  end

  a_r2_wrap_to_u: assert property (@(posedge clk) disable iff (rst)
    (adv_o && !half_rate_i && ph_q == PH_Y0) |=> ph_q == PH_U);
  a_r3_second_y: assert property (@(posedge clk) disable iff (rst)
    (adv_o && half_rate_i && ph_q == PH_Y0) |=> ph_q == PH_Y1);
  a_r8_restart: assert property (@(posedge clk) disable iff (rst)
    line_start_i |=> ph_q == PH_U);
  a_r9_stall: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !line_start_i) |=> $stable(ph_q));
endmodule

// File: rtl/yuv_seq_dline.sv
module yuv_seq_dline #(
  parameter int PIX_W = 8,
  parameter int TAPS  = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  shift_i,
  input  logic [PIX_W-1:0]      din_i,
  output logic [TAPS*PIX_W-1:0] next_taps_o
);
  localparam int STAGES = TAPS - 1;

  logic [PIX_W-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else if (shift_i) begin
      stg_q[0] <= din_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign next_taps_o[PIX_W-1:0] = din_i;
  for (genvar k = 1; k < TAPS; k++) begin : g_tap
    assign next_taps_o[k*PIX_W +: PIX_W] = stg_q[k-1];
  end

  a_r4_chain_idle: assert property (@(posedge clk) disable iff (rst)
    !shift_i |=> $stable(stg_q[STAGES-1]) && $stable(stg_q[0]));
endmodule

// File: rtl/yuv_seq_pair.sv
module yuv_seq_pair
  import yuv_seq_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld_i,
  input  logic [1:0]       comp_i,
  input  logic [PIX_W-1:0] filt_i,
  output logic             pix_vld_o,
  output logic [PIX_W-1:0] pix_y_o,
  output logic [PIX_W-1:0] pix_u_o,
  output logic [PIX_W-1:0] pix_v_o
);
  logic [PIX_W-1:0] u_hold_q, v_hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      u_hold_q  <= '0;
      v_hold_q  <= '0;
      pix_vld_o <= 1'b0;
      pix_y_o   <= '0;
      pix_u_o   <= '0;
      pix_v_o   <= '0;
    end else begin
      pix_vld_o <= vld_i && comp_i[1];
      if (vld_i) begin
        if (comp_i == PH_U) u_hold_q <= filt_i;
        if (comp_i == PH_V) v_hold_q <= filt_i;
        if (comp_i[1]) begin
          pix_y_o <= filt_i;
          pix_u_o <= u_hold_q;
          pix_v_o <= v_hold_q;
        end
      end
    end
  end

  a_r6_u_capture: assert property (@(posedge clk) disable iff (rst)
    (vld_i && comp_i == PH_U) |=> u_hold_q == $past(filt_i));
  a_r6_v_capture: assert property (@(posedge clk) disable iff (rst)
    (vld_i && comp_i == PH_V) |=> v_hold_q == $past(filt_i));
  a_r7_luma_only: assert property (@(posedge clk) disable iff (rst)
    pix_vld_o |-> $past(vld_i) && $past(comp_i[1]));
endmodule

// File: rtl/yuv_interleave_seq.sv
module yuv_interleave_seq
  import yuv_seq_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int TAPS   = 5,
  parameter int CSEL_W = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en_i,
  input  logic                   line_start_i,
  input  logic                   half_rate_i,
  input  logic [PIX_W-1:0]       pix_i,
  input  logic [TAPS*CSEL_W-1:0] coef_u_i,
  input  logic [TAPS*CSEL_W-1:0] coef_v_i,
  input  logic [TAPS*CSEL_W-1:0] coef_y_i,
  input  logic [PIX_W-1:0]       filt_i,
  output logic [1:0]             phase_o,
  output logic                   tap_vld_o,
  output logic [1:0]             tap_comp_o,
  output logic [TAPS*PIX_W-1:0]  taps_o,
  output logic [TAPS*CSEL_W-1:0] csel_o,
  output logic                   pix_vld_o,
  output logic [PIX_W-1:0]       pix_y_o,
  output logic [PIX_W-1:0]       pix_u_o,
  output logic [PIX_W-1:0]       pix_v_o
);
  localparam int TAP_BITS = TAPS * PIX_W;

  logic                  adv;
  logic [1:0]            phase;
  logic [TAP_BITS-1:0]   line_taps [NUM_STREAMS];
  logic [TAP_BITS-1:0]   tap_mux;
  logic [TAPS*CSEL_W-1:0] csel_mux;
  int                    sidx;

  yuv_seq_ctr u_ctr (
    .clk          (clk),
    .rst          (rst),
    .en_i         (en_i),
    .line_start_i (line_start_i),
    .half_rate_i  (half_rate_i),
    .phase_o      (phase),
    .adv_o        (adv)
  );

  assign phase_o = phase;
  assign sidx    = stream_of(phase);

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
    yuv_seq_dline #(.PIX_W(PIX_W), .TAPS(TAPS)) u_dline (
      .clk         (clk),
      .rst         (rst),
      .shift_i     (adv && (sidx == s)),
      .din_i       (pix_i),
      .next_taps_o (line_taps[s])
    );
  end

  always_comb begin
    case (sidx)
      0:       begin tap_mux = line_taps[0]; csel_mux = coef_u_i; end
      1:       begin tap_mux = line_taps[1]; csel_mux = coef_v_i; end
      default: begin tap_mux = line_taps[2]; csel_mux = coef_y_i; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tap_vld_o  <= 1'b0;
      tap_comp_o <= PH_U;
      taps_o     <= '0;
      csel_o     <= '0;
    end else begin
      tap_vld_o <= adv;
      if (adv) begin
        tap_comp_o <= phase;
        taps_o     <= tap_mux;
        csel_o     <= csel_mux;
      end
    end
  end

  yuv_seq_pair #(.PIX_W(PIX_W)) u_pair (
    .clk       (clk),
    .rst       (rst),
    .vld_i     (tap_vld_o),
    .comp_i    (tap_comp_o),
    .filt_i    (filt_i),
    .pix_vld_o (pix_vld_o),
    .pix_y_o   (pix_y_o),
    .pix_u_o   (pix_u_o),
    .pix_v_o   (pix_v_o)
  );

  a_r5_tag_matches: assert property (@(posedge clk) disable iff (rst)
    adv |=> tap_vld_o && tap_comp_o == $past(phase));
  a_r5_no_adv: assert property (@(posedge clk) disable iff (rst)
    !adv |=> !tap_vld_o);
  a_r2_no_code3: assert property (@(posedge clk) disable iff (rst)
    (!half_rate_i && phase != PH_Y1) |=> phase != PH_Y1);
endmodule

// File: tb/yuv_interleave_seq_tb.sv
module yuv_interleave_seq_tb;
  localparam int W = 8, T = 5, C = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_i = 1'b0, line_start_i = 1'b0, half_rate_i = 1'b0;
  logic [W-1:0] pix_i = '0;
  logic [T*C-1:0] coef_u_i = 25'h0A5_1234, coef_v_i = 25'h14C_7E01, coef_y_i = 25'h1F0_0F3C;
  logic [W-1:0] filt_i;
  logic [1:0] phase_o, tap_comp_o;
  logic tap_vld_o, pix_vld_o;
  logic [T*W-1:0] taps_o;
  logic [T*C-1:0] csel_o;
  logic [W-1:0] pix_y_o, pix_u_o, pix_v_o;

  always #10 clk = ~clk;

  function automatic logic [W-1:0] filt_of(input logic [T*W-1:0] t);
    logic [W-1:0] acc = '0;
    for (int i = 0; i < T; i++) acc += t[i*W +: W] * W'(i + 1);
    return acc;
  endfunction

  assign filt_i = filt_of(taps_o);

  yuv_interleave_seq #(.PIX_W(W), .TAPS(T), .CSEL_W(C)) u_dut (.*);

  int total = 0, bad = 0;
  logic [1:0] m_ph = 0, m_comp = 0;
  logic [W-1:0] m_dl [3][T-1];
  logic [T*W-1:0] m_taps = '0;
  logic m_tvld = 0, m_ovld = 0;
  logic [W-1:0] m_hu = 0, m_hv = 0, m_y = 0, m_u = 0, m_v = 0;
  int cyc = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic model_edge(input logic en, input logic ls, input logic hf, input logic [W-1:0] px);
    int s;
    logic [W-1:0] r;
    m_ovld = 1'b0;
    if (m_tvld) begin
      r = filt_of(m_taps);
      if (m_comp == 0) m_hu = r;
      else if (m_comp == 1) m_hv = r;
      else begin m_y = r; m_u = m_hu; m_v = m_hv; m_ovld = 1'b1; end
    end
    if (ls) begin
      m_ph = 0; m_tvld = 0;
    end else if (en) begin
      s = m_ph[1] ? 2 : int'(m_ph[0]);
      m_taps[W-1:0] = px;
      for (int k = 1; k < T; k++) m_taps[k*W +: W] = m_dl[s][k-1];
      for (int k = T-2; k > 0; k--) m_dl[s][k] = m_dl[s][k-1];
      m_dl[s][0] = px;
      m_tvld = 1; m_comp = m_ph;
      m_ph = (m_ph == 2) ? (hf ? 2'd3 : 2'd0) : (m_ph == 3) ? 2'd0 : m_ph + 2'd1;
    end else m_tvld = 0;
  endtask

  task automatic compare();
    chk(half_rate_i ? "R3 phase" : "R2 phase", phase_o, m_ph);
    chk("R9/R5 tap_vld", tap_vld_o, m_tvld);
    if (m_tvld) begin
      chk("R4 taps", taps_o, m_taps);
      chk("R5 comp", tap_comp_o, m_comp);
      chk("R5 csel", csel_o, m_comp == 0 ? coef_u_i : m_comp == 1 ? coef_v_i : coef_y_i);
    end
    chk("R7 pix_vld", pix_vld_o, m_ovld);
    if (m_ovld) begin
      chk("R7 pix_y", pix_y_o, m_y);
      chk("R6 pix_u", pix_u_o, m_u);
      chk("R6 pix_v", pix_v_o, m_v);
    end
  endtask

  task automatic step(input logic en, input logic ls, input logic hf);
    logic [W-1:0] px = W'(cyc * 37 + 11);
    en_i = en; line_start_i = ls; half_rate_i = hf; pix_i = px;
    @(posedge clk);
    model_edge(en, ls, hf, px);
    cyc++;
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < 3; s++) for (int k = 0; k < T-1; k++) m_dl[s][k] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 phase", phase_o, 0);
    chk("R1 tap_vld", tap_vld_o, 0);
    chk("R1 pix_vld", pix_vld_o, 0);
    chk("R1 taps", taps_o, 0);
    // R2/R3/R4/R9 sweep: both rates, every stall spacing
    for (int hf = 0; hf < 2; hf++) begin
      for (int sp = 0; sp < 4; sp++) begin
        step(1'b1, 1'b1, 1'(hf));
        for (int n = 0; n < 40; n++) step(sp == 3 || (n % 4) != sp, 1'b0, 1'(hf));
      end
    end
    // R8: restart from every phase, en high and low during the pulse
    for (int hf = 0; hf < 2; hf++) begin
      for (int off = 0; off < 5; off++) begin
        for (int n = 0; n < off; n++) step(1'b1, 1'b0, 1'(hf));
        step(1'(off % 2), 1'b1, 1'(hf));
        for (int n = 0; n < 6; n++) step(1'b1, 1'b0, 1'(hf));
      end
    end
    // mode switching mid-line
    for (int n = 0; n < 30; n++) step(1'b1, 1'b0, 1'((n / 5) % 2));
    // R9: long stall keeps everything
    for (int n = 0; n < 6; n++) step(1'b0, 1'b0, 1'b0);
    for (int n = 0; n < 8; n++) step(1'b1, 1'b0, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule